// File: doc/BRIEF.md
# Framebuffer Scan-Out Fetch Engine

This block turns pixel coordinates from an upstream video-timing generator into memory read requests for a fixed 640x480 true-colour image. It then unpacks each returned 32-bit word into separate 8-bit red, green and blue outputs. A processor programs it through two 32-bit registers. Word 0 holds the image base address and word 1 holds a control word with a display-enable bit and a 180-degree rotation bit.

Each image row takes 1024 words of memory, but only the first 640 are on screen. The base address keeps only its upper 11 bits, so an image always starts on a 2 MB boundary. Register writes land in shadow copies. The copies used for scanning pick them up only at the first pixel of a frame, so a frame is never torn. Rotation reverses both the column and the row order, which turns the image upside down.

The block drives a simple request/valid read port. Read data is expected a fixed number of cycles after each request. Sync generation, the memory fabric and the panel drivers are outside the block.

Top module: `scanout_fetch`

## Requirements
- R1: After reset both registers read back as zero, `mem_req` is low, `rgb_valid` is low and the colour outputs are zero.
- R2: A write to register word 0 (`reg_addr`=0) keeps bits 31:21 only, and reading word 0 returns those bits with bits 20:0 as zero.
- R3: In register word 1, bit 0 is display enable and bit 1 is rotation. All other bits read back as zero, and writing zero to the word turns the display off.
- R4: New register values take effect only on a strobe at column 0, row 0, and that strobe already uses them. Strobes at other coordinates keep using the previous settings.
- R5: With rotation off, a strobe on an enabled display raises `mem_req` in the next cycle with `mem_addr` = base + row*4096 + col*4.
- R6: With rotation on, the address is base + (479-row)*4096 + (639-col)*4.
- R7: A strobe with column 640 or more, or row 480 or more, issues no request, so the 384 unused words of each row are never fetched.
- R8: While the display is disabled, strobes issue no memory requests.
- R9: One cycle after `mem_rvalid`, `rgb_valid` is high with red = data bits 23:16, green = bits 15:8 and blue = bits 7:0. Bits 31:24 are ignored.
- R10: Whenever `rgb_valid` is low, `red`, `green` and `blue` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register word select: 0 = base, 1 = control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered readback of the selected register |
| pix_strobe | input | 1 | Pixel timing strobe |
| pix_col | input | 10 | Pixel column |
| pix_row | input | 9 | Pixel row |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the pixel word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| red | output | 8 | Red level |
| green | output | 8 | Green level |
| blue | output | 8 | Blue level |
| rgb_valid | output | 1 | Colour outputs valid |

## Verification
The assertions check on every cycle the rules that hold for any stimulus:
- a request only follows an in-range strobe;
- the colour outputs track returned data one cycle later, and are black when not valid;
- readback never shows the dropped base bits or the unused control bits.

Some behaviours need a known stimulus and can only be shown by the bench scenarios. These are the exact address arithmetic in both scan orders, the deferral of register writes to the frame start, and the suppression of requests while the display is disabled.

// File: rtl/scanout_pkg.sv
package scanout_pkg;
  localparam logic REG_SEL_BASE = 1'b0;
  localparam logic REG_SEL_CTRL = 1'b1;
  localparam int   CTRL_EN_BIT  = 0;
  localparam int   CTRL_ROT_BIT = 1;

  typedef struct packed {
    logic en;
    logic rot;
  } scan_ctrl_t;
endpackage

// File: rtl/scanout_regs.sv
module scanout_regs
  import scanout_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LOW_BITS = 21,
  localparam int KEEP_W  = ADDR_W - LOW_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              frame_start,
  output logic [KEEP_W-1:0] base_eff,
  output scan_ctrl_t        ctrl_eff
);
  logic [KEEP_W-1:0] base_shadow, base_act;
  scan_ctrl_t        ctrl_shadow, ctrl_act;

  // Processor-visible shadow copies
  always_ff @(posedge clk) begin
    if (rst) begin
      base_shadow <= '0;
      ctrl_shadow <= '0;
    end else if (we) begin
      if (sel == REG_SEL_BASE) base_shadow <= wdata[ADDR_W-1:LOW_BITS];
      else begin
        ctrl_shadow.en  <= wdata[CTRL_EN_BIT];
        ctrl_shadow.rot <= wdata[CTRL_ROT_BIT];
      end
    end
  end

  // Scanning copies, refreshed only at the first pixel of a frame
  always_ff @(posedge clk) begin
    if (rst) begin
      base_act <= '0;
      ctrl_act <= '0;
    end else if (frame_start) begin
      base_act <= base_shadow;
      ctrl_act <= ctrl_shadow;
    end
  end

  assign base_eff = frame_start ? base_shadow : base_act;
  assign ctrl_eff = frame_start ? ctrl_shadow : ctrl_act;

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (sel == REG_SEL_BASE) rdata <= {base_shadow, {LOW_BITS{1'b0}}};
    else begin
      rdata <= '0;
      rdata[CTRL_EN_BIT]  <= ctrl_shadow.en;
      rdata[CTRL_ROT_BIT] <= ctrl_shadow.rot;
    end
  end
endmodule

// File: rtl/scanout_addr.sv
module scanout_addr
  import scanout_pkg::*;
#(
  parameter int H_ACTIVE    = 640,
  parameter int V_ACTIVE    = 480,
  parameter int PITCH_WORDS = 1024,
  parameter int ADDR_W      = 32,
  parameter int BYTE_BITS   = 2,
  localparam int COL_W  = $clog2(PITCH_WORDS),
  localparam int ROW_W  = $clog2(V_ACTIVE),
  localparam int KEEP_W = ADDR_W - ROW_W - COL_W - BYTE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  row,
  input  logic [KEEP_W-1:0] base,
  input  scan_ctrl_t        ctrl,
  output logic              req,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_ACTIVE - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(V_ACTIVE - 1);

  logic             in_range;
  logic [COL_W-1:0] col_sel;
  logic [ROW_W-1:0] row_sel;

  always_comb begin
    in_range = ({1'b0, col} < (COL_W+1)'(H_ACTIVE)) &&
               ({1'b0, row} < (ROW_W+1)'(V_ACTIVE));
    col_sel  = ctrl.rot ? (COL_LAST - col) : col;
    row_sel  = ctrl.rot ? (ROW_LAST - row) : row;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      addr <= '0;
    end else begin
      req <= strobe && ctrl.en && in_range;
      if (strobe && ctrl.en && in_range)
        addr <= {base, row_sel, col_sel, {BYTE_BITS{1'b0}}};
    end
  end
endmodule

// File: rtl/scanout_unpack.sv
module scanout_unpack #(
  parameter int DATA_W = 32,
  parameter int CH_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] rdata,
  output logic [CH_W-1:0]   red,
  output logic [CH_W-1:0]   green,
  output logic [CH_W-1:0]   blue,
  output logic              valid
);
  always_ff @(posedge clk) begin
    if (rst || !rvalid) begin
      red   <= '0;
      green <= '0;
      blue  <= '0;
      valid <= 1'b0;
    end else begin
      red   <= rdata[3*CH_W-1:2*CH_W];
      green <= rdata[2*CH_W-1:CH_W];
      blue  <= rdata[CH_W-1:0];
      valid <= 1'b1;
    end
  end
endmodule

// File: rtl/scanout_fetch.sv
module scanout_fetch
  import scanout_pkg::*;
#(
  parameter int H_ACTIVE    = 640,
  parameter int V_ACTIVE    = 480,
  parameter int PITCH_WORDS = 1024,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CH_W        = 8,
  localparam int COL_W     = $clog2(PITCH_WORDS),
  localparam int ROW_W     = $clog2(V_ACTIVE),
  localparam int BYTE_BITS = $clog2(DATA_W/8),
  localparam int LOW_BITS  = ROW_W + COL_W + BYTE_BITS,
  localparam int KEEP_W    = ADDR_W - LOW_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pix_strobe,
  input  logic [COL_W-1:0]  pix_col,
  input  logic [ROW_W-1:0]  pix_row,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CH_W-1:0]   red,
  output logic [CH_W-1:0]   green,
  output logic [CH_W-1:0]   blue,
  output logic              rgb_valid
);
  logic              frame_start;
  logic [KEEP_W-1:0] base_eff;
  scan_ctrl_t        ctrl_eff;

  assign frame_start = pix_strobe && (pix_col == '0) && (pix_row == '0);

  scanout_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_BITS(LOW_BITS)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .frame_start(frame_start),
    .base_eff(base_eff), .ctrl_eff(ctrl_eff)
  );

  scanout_addr #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .PITCH_WORDS(PITCH_WORDS),
    .ADDR_W(ADDR_W), .BYTE_BITS(BYTE_BITS)
  ) u_addr (
    .clk(clk), .rst(rst), .strobe(pix_strobe), .col(pix_col), .row(pix_row),
    .base(base_eff), .ctrl(ctrl_eff), .req(mem_req), .addr(mem_addr)
  );

  scanout_unpack #(.DATA_W(DATA_W), .CH_W(CH_W)) u_unpack (
    .clk(clk), .rst(rst), .rvalid(mem_rvalid), .rdata(mem_rdata),
    .red(red), .green(green), .blue(blue), .valid(rgb_valid)
  );
endmodule

// File: rtl/scanout_fetch_chk.sv
module scanout_fetch_chk #(
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480,
  parameter int COL_W    = 10,
  parameter int ROW_W    = 9,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int CH_W     = 8,
  parameter int LOW_BITS = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              pix_strobe,
  input logic [COL_W-1:0]  pix_col,
  input logic [ROW_W-1:0]  pix_row,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [CH_W-1:0]   red,
  input logic [CH_W-1:0]   green,
  input logic [CH_W-1:0]   blue,
  input logic              rgb_valid
);
  // R5
  req_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $past(pix_strobe));

  // R7
  req_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ($past(int'(pix_col)) < H_ACTIVE && $past(int'(pix_row)) < V_ACTIVE));

  // R5
  addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R9
  rgb_follows_data_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |=> (rgb_valid && red == $past(mem_rdata[3*CH_W-1:2*CH_W]) &&
                    green == $past(mem_rdata[2*CH_W-1:CH_W]) &&
                    blue == $past(mem_rdata[CH_W-1:0])));

  // R9
  rgb_valid_source_chk: assert property (@(posedge clk) disable iff (rst)
    rgb_valid |-> $past(mem_rvalid));

  // R10
  black_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rgb_valid |-> (red == '0 && green == '0 && blue == '0));

  // R2
  base_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reg_addr == 1'b0) |-> (reg_rdata[LOW_BITS-1:0] == '0));

  // R3
  ctrl_unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reg_addr == 1'b1) |-> (reg_rdata[DATA_W-1:2] == '0));
endmodule

bind scanout_fetch scanout_fetch_chk #(
  .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .COL_W(COL_W), .ROW_W(ROW_W),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .LOW_BITS(LOW_BITS)
) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .pix_strobe(pix_strobe), .pix_col(pix_col), .pix_row(pix_row),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
  .mem_rdata(mem_rdata), .red(red), .green(green), .blue(blue),
  .rgb_valid(rgb_valid)
);

// File: tb/scanout_fetch_bench.sv
module scanout_fetch_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pix_strobe = 1'b0;
  logic [9:0]  pix_col = '0;
  logic [8:0]  pix_row = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic [7:0]  red, green, blue;
  logic        rgb_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scanout_fetch u_scanout_fetch (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_strobe(pix_strobe),
    .pix_col(pix_col), .pix_row(pix_row), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .red(red), .green(green), .blue(blue), .rgb_valid(rgb_valid)
  );

  // Memory model: two-cycle read latency, data derived from the address
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {8'hEE, a[19:12] ^ 8'h0F, a[9:2], a[27:20]};
  endfunction

  logic        m_s1 = 1'b0, m_v = 1'b0;
  logic [31:0] m_a1 = '0, m_d = '0;
  logic        inj_v = 1'b0;
  logic [31:0] inj_d = '0;
  always @(posedge clk) begin
    m_s1 <= rst ? 1'b0 : mem_req;
    m_a1 <= mem_addr;
    m_v  <= rst ? 1'b0 : m_s1;
    m_d  <= mem_word(m_a1);
  end
  assign mem_rvalid = m_v | inj_v;
  assign mem_rdata  = inj_v ? inj_d : m_d;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  // Strobe one pixel; check the request, then the colour three edges later
  task automatic pixel(input logic [9:0] c, input logic [8:0] r, input bit exp_req,
                       input logic [31:0] exp_addr, input string req);
    logic [31:0] w;
    @(negedge clk);
    pix_strobe = 1'b1; pix_col = c; pix_row = r;
    @(negedge clk);
    pix_strobe = 1'b0;
    chk(mem_req == exp_req, req, {31'b0, mem_req}, {31'b0, exp_req});
    if (exp_req) chk(mem_addr == exp_addr, req, mem_addr, exp_addr);
    repeat (3) @(negedge clk);
    w = exp_req ? {8'h00, mem_word(exp_addr)[23:0]} : 32'h0;
    chk(rgb_valid == exp_req && {8'h00, red, green, blue} == w,
        exp_req ? "R9" : "R10", {7'b0, rgb_valid, red, green, blue},
        {7'b0, exp_req, w[23:0]});
  endtask

  // {rotate, col, row, expected byte address} with base 0x12200000
  localparam int NV = 11;
  localparam logic [51:0] VEC [NV] = '{
    {1'b0, 10'd0,   9'd0,   32'h1220_0000},
    {1'b0, 10'd1,   9'd0,   32'h1220_0004},
    {1'b0, 10'd639, 9'd0,   32'h1220_09FC},
    {1'b0, 10'd0,   9'd1,   32'h1220_1000},
    {1'b0, 10'd639, 9'd479, 32'h123D_F9FC},
    {1'b0, 10'd100, 9'd200, 32'h122C_8190},
    {1'b1, 10'd0,   9'd0,   32'h123D_F9FC},
    {1'b1, 10'd639, 9'd479, 32'h1220_0000},
    {1'b1, 10'd639, 9'd0,   32'h123D_F000},
    {1'b1, 10'd0,   9'd479, 32'h1220_09FC},
    {1'b1, 10'd100, 9'd200, 32'h1231_786C}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(mem_req == 1'b0 && rgb_valid == 1'b0, "R1", {30'b0, mem_req, rgb_valid}, 32'h0);
    chk({red, green, blue} == 24'h0, "R1", {8'h0, red, green, blue}, 32'h0);
    rd_chk(1'b0, 32'h0, "R1");
    rd_chk(1'b1, 32'h0, "R1");

    // R2 base keeps bits 31:21; R3 unused control bits read zero
    wr(1'b0, 32'h1234_5678);
    rd_chk(1'b0, 32'h1220_0000, "R2");
    wr(1'b1, 32'hFFFF_FFFF);
    rd_chk(1'b1, 32'h0000_0003, "R3");

    // Table walk: R5 (rotation off) and R6 (rotation on)
    for (int i = 0; i < NV; i++) begin
      wr(1'b1, {30'b0, VEC[i][51], 1'b1});
      pixel(10'd0, 9'd0, 1'b1, VEC[i][51] ? 32'h123D_F9FC : 32'h1220_0000, "R4");
      pixel(VEC[i][50:41], VEC[i][40:32], 1'b1, VEC[i][31:0],
            VEC[i][51] ? "R6" : "R5");
    end

    // R4: new base waits for frame start; frame start uses it at once
    wr(1'b1, 32'h1);
    pixel(10'd0, 9'd0, 1'b1, 32'h1220_0000, "R4");
    wr(1'b0, 32'h4000_0000);
    pixel(10'd2, 9'd1, 1'b1, 32'h1220_1008, "R4");
    pixel(10'd0, 9'd0, 1'b1, 32'h4000_0000, "R4");

    // R3/R8: writing zero disables from the next frame start on
    wr(1'b1, 32'h0);
    rd_chk(1'b1, 32'h0, "R3");
    pixel(10'd3, 9'd3, 1'b1, 32'h4000_300C, "R4");
    pixel(10'd0, 9'd0, 1'b0, 32'h0, "R8");
    pixel(10'd5, 9'd7, 1'b0, 32'h0, "R8");

    // R7: coordinates beyond the visible area are never fetched
    wr(1'b1, 32'h1);
    pixel(10'd0, 9'd0, 1'b1, 32'h4000_0000, "R4");
    pixel(10'd700, 9'd5, 1'b0, 32'h0, "R7");
    pixel(10'd640, 9'd0, 1'b0, 32'h0, "R7");
    pixel(10'd5, 9'd500, 1'b0, 32'h0, "R7");

    // R9: top byte of returned word ignored
    @(negedge clk);
    inj_v = 1'b1; inj_d = 32'hFF12_3456;
    @(negedge clk);
    inj_v = 1'b0;
    chk(rgb_valid && {red, green, blue} == 24'h123456, "R9",
        {7'b0, rgb_valid, red, green, blue}, 32'h0112_3456);
    @(negedge clk);
    chk(!rgb_valid && {red, green, blue} == 24'h0, "R10",
        {7'b0, rgb_valid, red, green, blue}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule